// File: doc/BRIEF.md
# Gear Ratio Divider Pair

This block makes two slow phase-reference clocks out of two unrelated clock domains, so that a downstream phase detector can compare them. On the bus side, the fast bus clock is first divided by four to form the interface clock. The interface clock is then divided by N to give the bus-side reference. On the controller side, the controller clock is divided by M to give the controller-side reference. M and N always come as a pair from a small table, picked by one select code. When the bus clock runs at four times the controller clock scaled by N/M, the two references have the same frequency.

Both dividers are reloading down-counters. A reference rises on the cycle its counter reloads. A new select code is taken up only at a reload, so every pulse is either wholly old or wholly new. Only rising edges carry meaning; the two references may have different duty cycles. Each domain has its own synchronous, active-high reset. While a domain is in reset, it samples the select code directly.

Top module: `gear_div_pair`

## Requirements
- R1: While ctl_rst is high, ref_m is low. While bus_rst is high, ref_n and if_clk are low.
- R2: if_clk repeats every 4 bus_clk cycles and is high for 2 of them.
- R3: ref_m repeats every M ctl_clk cycles and is high for floor(M/2) of them.
- R4: ref_n repeats every N interface periods (4N bus_clk cycles) and is high for floor(N/2) interface periods (4*floor(N/2) bus_clk cycles).
- R5: ratio_sel picks the pair (M,N) as follows: 0 gives (2,2), 1 gives (4,4), 2 gives (4,2), 3 gives (8,6), 4 gives (4,3).
- R6: Every rising edge of ref_n falls on the same bus_clk edge as a rising edge of if_clk.
- R7: A change of ratio_sel takes effect in each domain only when that domain's counter reloads. The period in progress finishes with its old length and old high time.
- R8: Codes 5, 6 and 7 hold ref_m and ref_n low from the next reload on, while if_clk keeps running. A later valid code restarts both references.
- R9: When the bus_clk frequency is 4*N/M times the ctl_clk frequency, ref_m and ref_n show the same number of rising edges, within one, over any common window.
- R10: The first bus_clk edge after bus_rst falls raises both ref_n and if_clk. The first ctl_clk edge after ctl_rst falls raises ref_m. Both use the code held during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| ctl_clk | input | 1 | Controller clock |
| ctl_rst | input | 1 | Synchronous active-high reset, controller domain |
| ratio_sel | input | 3 | Gear ratio code, asynchronous to both clocks |
| if_clk | output | 1 | Interface clock, bus_clk divided by 4 |
| ref_n | output | 1 | Interface clock divided by N |
| ref_m | output | 1 | Controller clock divided by M |

## Verification
Two events can land in the same cycle: a new ratio code arriving and a counter reaching its reload. If they meet badly, a short pulse can appear. The bench changes the code in the cycle just after a reference rises. This lets the new code pass through the synchronizer well before the reload. The bench then requires exactly one full period of the old shape, followed by a full period of the new shape. A second coincidence is built into the bus side: the N divider reloads on the same edge where the interface clock rises. The bench checks at every ref_n rise that if_clk rose in that same cycle.

// File: rtl/gear_div_pair.sv
`timescale 1ns/1ps
module gear_div_pair #(
  parameter int CW     = 4,
  parameter int SW     = 3,
  parameter int IF_DIV = 4
) (
  input  logic          bus_clk,
  input  logic          bus_rst,
  input  logic          ctl_clk,
  input  logic          ctl_rst,
  input  logic [SW-1:0] ratio_sel,
  output logic          if_clk,
  output logic          ref_n,
  output logic          ref_m
);

  localparam int QW = $clog2(IF_DIV);
  localparam logic [QW-1:0] Q_LAST = QW'(IF_DIV - 1);
  localparam logic [QW-1:0] Q_HALF = QW'(IF_DIV / 2);

  function automatic logic [CW:0] pick(input logic [SW-1:0] s, input logic for_m);
    logic [CW-1:0] m, n;
    logic ok;
    ok = 1'b1;
    case (s)
      SW'(0):  begin m = CW'(2); n = CW'(2); end
      SW'(1):  begin m = CW'(4); n = CW'(4); end
      SW'(2):  begin m = CW'(4); n = CW'(2); end
      SW'(3):  begin m = CW'(8); n = CW'(6); end
      SW'(4):  begin m = CW'(4); n = CW'(3); end
      default: begin m = '0; n = '0; ok = 1'b0; end
    endcase
    return {ok, for_m ? m : n};
  endfunction

  // controller domain
  logic [SW-1:0] m_s1, m_s2, m_s3;
  logic [CW-1:0] m_cnt, m_div, m_div_nx, m_cnt_nx;
  logic [CW:0]   m_look;
  logic          m_ok, m_ok_nx, m_term, m_take;

  assign m_look   = pick(m_s2, 1'b1);
  assign m_term   = (m_cnt == '0);
  assign m_take   = m_term && (m_s2 == m_s3);
  assign m_div_nx = m_take ? m_look[CW-1:0] : m_div;
  assign m_ok_nx  = m_take ? m_look[CW] : m_ok;
  assign m_cnt_nx = m_term ? (m_ok_nx ? m_div_nx - 1'b1 : '0) : m_cnt - 1'b1;

  always_ff @(posedge ctl_clk) begin
    if (ctl_rst) begin
      m_s1  <= ratio_sel;
      m_s2  <= ratio_sel;
      m_s3  <= ratio_sel;
      m_cnt <= '0;
      m_div <= '0;
      m_ok  <= 1'b0;
      ref_m <= 1'b0;
    end else begin
      m_s1  <= ratio_sel;
      m_s2  <= m_s1;
      m_s3  <= m_s2;
      m_cnt <= m_cnt_nx;
      m_div <= m_div_nx;
      m_ok  <= m_ok_nx;
      ref_m <= m_ok_nx && (m_cnt_nx >= m_div_nx - (m_div_nx >> 1));
    end
  end

  // bus domain
  logic [QW-1:0] q, q_nx;
  logic          tick;
  logic [SW-1:0] n_s1, n_s2, n_s3;
  logic [CW-1:0] n_cnt, n_div, n_div_nx, n_cnt_nx;
  logic [CW:0]   n_look;
  logic          n_ok, n_ok_nx, n_term, n_take;

  assign tick     = (q == Q_LAST);
  assign q_nx     = tick ? '0 : q + 1'b1;
  assign n_look   = pick(n_s2, 1'b0);
  assign n_term   = (n_cnt == '0);
  assign n_take   = n_term && (n_s2 == n_s3);
  assign n_div_nx = n_take ? n_look[CW-1:0] : n_div;
  assign n_ok_nx  = n_take ? n_look[CW] : n_ok;
  assign n_cnt_nx = n_term ? (n_ok_nx ? n_div_nx - 1'b1 : '0) : n_cnt - 1'b1;

  always_ff @(posedge bus_clk) begin
    if (bus_rst) begin
      q      <= Q_LAST;
      if_clk <= 1'b0;
      n_s1   <= ratio_sel;
      n_s2   <= ratio_sel;
      n_s3   <= ratio_sel;
      n_cnt  <= '0;
      n_div  <= '0;
      n_ok   <= 1'b0;
      ref_n  <= 1'b0;
    end else begin
      q      <= q_nx;
      if_clk <= (q_nx < Q_HALF);
      n_s1   <= ratio_sel;
      n_s2   <= n_s1;
      n_s3   <= n_s2;
      if (tick) begin
        n_cnt <= n_cnt_nx;
        n_div <= n_div_nx;
        n_ok  <= n_ok_nx;
        ref_n <= n_ok_nx && (n_cnt_nx >= n_div_nx - (n_div_nx >> 1));
      end
    end
  end

  // R1
  ctl_rst_low_chk: assert property (@(posedge ctl_clk) ctl_rst |=> !ref_m);
  // R1
  bus_rst_low_chk: assert property (@(posedge bus_clk) bus_rst |=> (!ref_n && !if_clk));
  // R2
  if_hi_chk: assert property (@(posedge bus_clk) disable iff (bus_rst) $rose(if_clk) |=> if_clk);
  // R2
  if_lo_chk: assert property (@(posedge bus_clk) disable iff (bus_rst) $fell(if_clk) |=> !if_clk);
  // R3
  m_rise_reload_chk: assert property (@(posedge ctl_clk) disable iff (ctl_rst)
    $rose(ref_m) |-> (m_cnt == m_div - 1'b1));
  // R6
  n_align_chk: assert property (@(posedge bus_clk) disable iff (bus_rst) $rose(ref_n) |-> $rose(if_clk));
  // R7
  m_div_hold_chk: assert property (@(posedge ctl_clk) disable iff (ctl_rst)
    (m_cnt != '0) |=> $stable(m_div));
  // R7
  n_div_hold_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (n_cnt != '0) |=> $stable(n_div));

endmodule

// File: tb/sim_gear_div_pair.sv
`timescale 1ns/1ps
module sim_gear_div_pair;
  logic bus_clk = 1'b0, ctl_clk = 1'b0;
  logic bus_rst = 1'b1, ctl_rst = 1'b1;
  logic [2:0] ratio_sel = 3'd0;
  logic if_clk, ref_n, ref_m;
  realtime bus_half = 1.0;
  int n_chk = 0, n_bad = 0;
  int cnt_m = 0, cnt_n = 0;

  gear_div_pair u0 (.bus_clk(bus_clk), .bus_rst(bus_rst), .ctl_clk(ctl_clk), .ctl_rst(ctl_rst),
                    .ratio_sel(ratio_sel), .if_clk(if_clk), .ref_n(ref_n), .ref_m(ref_m));

  always #4 ctl_clk = ~ctl_clk;
  always #(bus_half) bus_clk = ~bus_clk;
  always @(posedge ref_m) cnt_m++;
  always @(posedge ref_n) cnt_n++;

  int mtab [5] = '{2, 4, 4, 8, 4};
  int ntab [5] = '{2, 4, 2, 6, 3};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int w);
    if (w == 0) @(negedge ctl_clk); else @(negedge bus_clk);
  endtask

  function automatic logic sig(input int w);
    return (w == 0) ? ref_m : (w == 1) ? ref_n : if_clk;
  endfunction

  task automatic wait_rise(input int w, output bit seen);
    bit pv = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 600 && !seen; i++) begin
      step(w);
      if (sig(w) && !pv) seen = 1'b1;
      pv = sig(w);
    end
  endtask

  task automatic shape(input int w, output int hi, output int per);
    bit low = 1'b0;
    hi = 1; per = 1;
    for (int i = 0; i < 600; i++) begin
      step(w);
      if (sig(w) && low) return;
      per++;
      if (sig(w)) hi++; else low = 1'b1;
    end
    per = -1;
  endtask

  task automatic settle();
    repeat (60) @(negedge ctl_clk);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge ctl_clk);
    chk(ref_m == 1'b0, "R1 ref_m in reset", ref_m, 0);
    chk(ref_n == 1'b0, "R1 ref_n in reset", ref_n, 0);
    chk(if_clk == 1'b0, "R1 if_clk in reset", if_clk, 0);
    ctl_rst = 1'b0;
    @(negedge ctl_clk);
    chk(ref_m == 1'b1, "R10 ref_m first edge", ref_m, 1);
    @(negedge bus_clk);
    chk(ref_n == 1'b0, "R1 ref_n bus still in reset", ref_n, 0);
    bus_rst = 1'b0;
    @(negedge bus_clk);
    chk(ref_n == 1'b1, "R10 ref_n first edge", ref_n, 1);
    chk(if_clk == 1'b1, "R10 if_clk first edge", if_clk, 1);
  endtask

  task automatic t_shape(input int c);
    bit s; int hi, per;
    ratio_sel = 3'(c); settle();
    wait_rise(0, s); shape(0, hi, per);
    chk(per == mtab[c], $sformatf("R3 R5 ref_m period code %0d", c), per, mtab[c]);
    chk(hi == mtab[c] / 2, $sformatf("R3 ref_m high code %0d", c), hi, mtab[c] / 2);
    wait_rise(1, s); shape(1, hi, per);
    chk(per == 4 * ntab[c], $sformatf("R4 R5 ref_n period code %0d", c), per, 4 * ntab[c]);
    chk(hi == 4 * (ntab[c] / 2), $sformatf("R4 ref_n high code %0d", c), hi, 4 * (ntab[c] / 2));
    wait_rise(2, s); shape(2, hi, per);
    chk(per == 4 && hi == 2, "R2 if_clk shape", per * 10 + hi, 42);
  endtask

  task automatic t_align();
    bit pn = 1'b1, pi = 1'b1;
    int bad = 0, seen = 0;
    ratio_sel = 3'd4; settle();
    for (int i = 0; i < 300; i++) begin
      @(negedge bus_clk);
      if (ref_n && !pn) begin
        seen++;
        if (!(if_clk && !pi)) bad++;
      end
      pn = ref_n; pi = if_clk;
    end
    chk(bad == 0 && seen > 5, "R6 ref_n rises with if_clk", bad, 0);
  endtask

  task automatic t_switch();
    bit s; int hi, per;
    ratio_sel = 3'd3; settle();
    wait_rise(0, s); ratio_sel = 3'd2;
    shape(0, hi, per);
    chk(per == 8 && hi == 4, "R7 ref_m old period kept", per * 10 + hi, 84);
    shape(0, hi, per);
    chk(per == 4 && hi == 2, "R7 ref_m new period", per * 10 + hi, 42);
    ratio_sel = 3'd3; settle(); settle();
    wait_rise(1, s); ratio_sel = 3'd2;
    shape(1, hi, per);
    chk(per == 24 && hi == 12, "R7 ref_n old period kept", per * 100 + hi, 2412);
    shape(1, hi, per);
    chk(per == 8 && hi == 4, "R7 ref_n new period", per * 100 + hi, 804);
  endtask

  task automatic t_bad(input int c);
    bit s; int hm = 0, hn = 0, hi, per;
    ratio_sel = 3'(c); settle();
    for (int i = 0; i < 50; i++) begin @(negedge ctl_clk); if (ref_m) hm++; end
    for (int i = 0; i < 200; i++) begin @(negedge bus_clk); if (ref_n) hn++; end
    chk(hm == 0, $sformatf("R8 ref_m held low code %0d", c), hm, 0);
    chk(hn == 0, $sformatf("R8 ref_n held low code %0d", c), hn, 0);
    wait_rise(2, s); shape(2, hi, per);
    chk(per == 4, "R8 if_clk keeps running", per, 4);
    ratio_sel = 3'd4; settle();
    wait_rise(0, s); shape(0, hi, per);
    chk(per == 4, "R8 ref_m resumes", per, 4);
  endtask

  task automatic t_freq(input int c);
    int a, b, da, db, ex;
    ratio_sel = 3'(c);
    bus_half = real'(mtab[c]) / real'(ntab[c]);
    settle(); settle();
    a = cnt_m; b = cnt_n;
    #20000;
    da = cnt_m - a; db = cnt_n - b;
    ex = 20000 / (8 * mtab[c]);
    chk((da - db) <= 1 && (db - da) <= 1, $sformatf("R9 equal edges code %0d", c), db, da);
    chk((da - ex) <= 1 && (ex - da) <= 1, $sformatf("R9 ref_m edge count code %0d", c), da, ex);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    for (int c = 0; c < 5; c++) t_shape(c);
    t_align();
    t_switch();
    t_bad(6);
    t_bad(7);
    t_bad(5);
    for (int c = 0; c < 5; c++) t_freq(c);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule